// File: doc/BRIEF.md
# Misaligned Access Bus Cycle Splitter

This block turns one byte, word (16-bit) or long-word (32-bit) request at any byte address into the shortest run of 16-bit bus cycles that covers it. Each bus cycle carries an even word address, a two-bit lane enable and, for writes, the request data steered onto the correct lanes. For reads, the block collects the slave's returned lanes and packs them into a right-justified result.

A requester raises a one-clock start strobe with address, size, direction and write data. The splitter then drives the slave for one, two or three clocks, depending on the size and on whether the address is odd. It ends with a one-clock done pulse. Byte order is big-endian: the byte at the lower address is the more significant one. In the bus word, the even-address byte travels in the high lane and the odd-address byte in the low lane. The slave answers a read within the same clock as the cycle strobe.

Top module: `xfer_splitter`

## Requirements
- R1: While reset is high and after it falls, `bus_valid`, `bus_be`, `done` and `rd_data` are all zero until a request is accepted.
- R2: A byte request at any address, and a word request at an even address, take exactly one bus cycle.
- R3: A word request at an odd address, and a long-word request at an even address, take exactly two bus cycles.
- R4: A long-word request at an odd address takes exactly three bus cycles.
- R5: Bus cycles go in ascending order. The first cycle's `bus_addr` is the request address with bit 0 cleared, and each later cycle adds 2.
- R6: `bus_be[1]` enables the high lane `bus_wdata[15:8]`, which holds the even-address byte. `bus_be[0]` enables the low lane `[7:0]`, which holds the odd-address byte. A lane is enabled exactly when its byte address lies inside the request, so an odd-address request starts with only the low lane enabled.
- R7: On writes, `bus_we` is high in every cycle. The request data is right-justified in `req_wdata`, and its most significant byte goes to the lowest address.
- R8: On reads, `rd_data` holds the requested bytes right-justified and zero-extended. The most significant byte comes from the lowest address. `rd_data` updates together with a one-clock `done` pulse in the clock after the last bus cycle. A write leaves `rd_data` unchanged.
- R9: A start strobe is accepted only while no bus cycle is running. A strobe during a transfer causes no extra bus cycle and no change to the running transfer.
- R10: Size code 2'b11 is treated as a long word. The size codes are 2'b00 byte, 2'b01 word and 2'b10 long word.
- R11: The first bus cycle is driven in the clock right after the edge that samples the start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-clock request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 word, 10/11 long word |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 4*LANE_W | Right-justified write data |
| bus_valid | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | ADDR_W | Even word address of the cycle |
| bus_be | output | 2 | Lane enables, bit 1 = high (even) lane |
| bus_wdata | output | 2*LANE_W | Write data on the lanes |
| bus_rdata | input | 2*LANE_W | Read data returned by the slave in the same clock |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 4*LANE_W | Right-justified read result |

## Verification
The bench sweeps every size code, including the alias 2'b11, across eight consecutive start addresses, four even and four odd. Each address is first written and then read back, and the slave is a byte memory compared against a reference copy. The even/odd split separates the one-, two- and three-cycle cases. Byte requests at odd addresses show that the low lane is chosen. Read-back after write shows the byte order in both directions. Per cycle, the bench compares address, lane enables and steered write lanes against values computed from the address arithmetic. Two extra transfers raise the start strobe mid-transfer to show it is ignored.

// File: rtl/xs_pkg.sv
package xs_pkg;

  localparam int XS_REQ_BYTES = 4;

  typedef enum logic [1:0] {
    XS_BYTE = 2'd0,
    XS_WORD = 2'd1,
    XS_LONG = 2'd2,
    XS_LALT = 2'd3
  } xs_size_e;

  // bytes covered by a size code; the spare code aliases the long word
  function automatic logic [2:0] xs_nbytes(input logic [1:0] sz);
    case (sz)
      XS_BYTE: xs_nbytes = 3'd1;
      XS_WORD: xs_nbytes = 3'd2;
      default: xs_nbytes = 3'd4;
    endcase
  endfunction

  // 16-bit cycles needed: ceil((offset + bytes) / 2)
  function automatic logic [1:0] xs_ncyc(input logic off, input logic [1:0] sz);
    logic [3:0] t;
    t = {3'd0, off} + {1'b0, xs_nbytes(sz)} + 4'd1;
    xs_ncyc = t[2:1];
  endfunction

endpackage

// File: rtl/xs_lane_plan.sv
module xs_lane_plan
  import xs_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                           off,
  input  logic [1:0]                     sz,
  input  logic [1:0]                     idx,
  input  logic [XS_REQ_BYTES*LANE_W-1:0] wdata,
  output logic [1:0]                     be,
  output logic [2*LANE_W-1:0]            lane_wdata
);

  localparam int REQ_W = XS_REQ_BYTES * LANE_W;

  logic [2:0] n;
  assign n = xs_nbytes(sz);

  // lane 0 = even address (high half of the bus word), lane 1 = odd address
  for (genvar l = 0; l < 2; l++) begin : g_lane
    int                rel;
    int                pick;
    logic              en_l;
    logic [LANE_W-1:0] byte_l;

    always_comb begin
      rel    = 2 * int'(idx) + l - int'(off);
      en_l   = (rel >= 0) && (rel < int'(n));
      pick   = en_l ? (int'(n) - 1 - rel) : 0;
      byte_l = wdata[LANE_W*pick +: LANE_W];
    end

    assign be[1-l]                               = en_l;
    assign lane_wdata[(1-l)*LANE_W +: LANE_W]    = byte_l;
  end

  // the picked byte index never leaves the request word
  always_comb begin
    a_r7_pick_range: assert (g_lane[0].pick * LANE_W < REQ_W && g_lane[1].pick * LANE_W < REQ_W);
  end

endmodule

// File: rtl/xs_rd_merge.sv
module xs_rd_merge
  import xs_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clr,
  input  logic                           cap,
  input  logic [1:0]                     be,
  input  logic [2*LANE_W-1:0]            rdata,
  output logic [XS_REQ_BYTES*LANE_W-1:0] acc_nxt
);

  localparam int ACC_W = XS_REQ_BYTES * LANE_W;

  logic [ACC_W-1:0] acc;

  // ascending addresses arrive most significant first: shift left, append
  always_comb begin
    case (be)
      2'b11:   acc_nxt = {acc[ACC_W-2*LANE_W-1:0], rdata};
      2'b10:   acc_nxt = {acc[ACC_W-LANE_W-1:0], rdata[2*LANE_W-1:LANE_W]};
      2'b01:   acc_nxt = {acc[ACC_W-LANE_W-1:0], rdata[LANE_W-1:0]};
      default: acc_nxt = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (cap)   acc <= acc_nxt;
  end

  a_r8_clear_excl: assert property (@(posedge clk) disable iff (rst) clr |-> !cap);

endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
  import xs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_start,
  input  logic                           req_write,
  input  logic [1:0]                     req_size,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [XS_REQ_BYTES*LANE_W-1:0] req_wdata,
  output logic                           bus_valid,
  output logic                           bus_we,
  output logic [ADDR_W-1:0]              bus_addr,
  output logic [1:0]                     bus_be,
  output logic [2*LANE_W-1:0]            bus_wdata,
  input  logic [2*LANE_W-1:0]            bus_rdata,
  output logic                           done,
  output logic [XS_REQ_BYTES*LANE_W-1:0] rd_data
);

  localparam int REQ_W = XS_REQ_BYTES * LANE_W;
  localparam int BUS_W = 2 * LANE_W;

  logic             s_off;
  logic [1:0]       s_sz;
  logic [1:0]       s_idx;
  logic [REQ_W-1:0] s_wdata;

  logic             accept;
  logic             cur_last;
  logic             p_off;
  logic [1:0]       p_sz;
  logic [1:0]       p_idx;
  logic [REQ_W-1:0] p_wdata;
  logic [1:0]       p_be;
  logic [BUS_W-1:0] p_lanes;
  logic [REQ_W-1:0] acc_nxt;

  assign accept   = req_start && !bus_valid;
  assign cur_last = (s_idx == xs_ncyc(s_off, s_sz) - 2'd1);

  // plan the cycle about to be driven: first of a new request, or next one
  assign p_off   = accept ? req_addr[0] : s_off;
  assign p_sz    = accept ? req_size    : s_sz;
  assign p_idx   = accept ? 2'd0        : s_idx + 2'd1;
  assign p_wdata = accept ? req_wdata   : s_wdata;

  xs_lane_plan #(.LANE_W(LANE_W)) u_plan (
    .off        (p_off),
    .sz         (p_sz),
    .idx        (p_idx),
    .wdata      (p_wdata),
    .be         (p_be),
    .lane_wdata (p_lanes)
  );

  xs_rd_merge #(.LANE_W(LANE_W)) u_merge (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept),
    .cap     (bus_valid && !bus_we),
    .be      (bus_be),
    .rdata   (bus_rdata),
    .acc_nxt (acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_be    <= '0;
      bus_wdata <= '0;
      done      <= 1'b0;
      rd_data   <= '0;
      s_off     <= 1'b0;
      s_sz      <= XS_BYTE;
      s_idx     <= '0;
      s_wdata   <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        bus_valid <= 1'b1;
        bus_we    <= req_write;
        bus_addr  <= {req_addr[ADDR_W-1:1], 1'b0};
        bus_be    <= p_be;
        bus_wdata <= p_lanes;
        s_off     <= req_addr[0];
        s_sz      <= req_size;
        s_idx     <= '0;
        s_wdata   <= req_wdata;
      end else if (bus_valid) begin
        if (cur_last) begin
          bus_valid <= 1'b0;
          bus_be    <= '0;
          done      <= 1'b1;
          if (!bus_we) rd_data <= acc_nxt;
        end else begin
          bus_addr  <= bus_addr + ADDR_W'(2);
          bus_be    <= p_be;
          bus_wdata <= p_lanes;
          s_idx     <= p_idx;
        end
      end
    end
  end

  // run length of consecutive bus cycles, for the cycle-count bound
  logic [2:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)            run_q <= '0;
    else if (bus_valid) run_q <= run_q + 3'd1;
    else                run_q <= '0;
  end

  a_r4_max_three:  assert property (@(posedge clk) disable iff (rst) bus_valid |-> run_q < 3'd3);
  a_r5_addr_even:  assert property (@(posedge clk) disable iff (rst) bus_valid |-> !bus_addr[0]);
  a_r5_addr_step:  assert property (@(posedge clk) disable iff (rst)
                     (bus_valid && $past(bus_valid)) |-> bus_addr == $past(bus_addr) + ADDR_W'(2));
  a_r6_lane_live:  assert property (@(posedge clk) disable iff (rst) bus_valid |-> bus_be != 2'b00);
  a_r7_we_steady:  assert property (@(posedge clk) disable iff (rst)
                     (bus_valid && $past(bus_valid)) |-> $stable(bus_we));
  a_r8_done_after: assert property (@(posedge clk) disable iff (rst) done |-> $past(bus_valid) && !bus_valid);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r11_launch:    assert property (@(posedge clk) disable iff (rst)
                     ($past(req_start) && !$past(bus_valid)) |-> bus_valid);

endmodule

// File: tb/sim_xfer_splitter.sv
`timescale 1ns/1ps
module sim_xfer_splitter;
  localparam int AW  = 16;
  localparam int MEM = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_start = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size  = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        bus_valid, bus_we, done;
  logic [AW-1:0] bus_addr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata, bus_rdata;
  logic [31:0] rd_data;

  always #2 clk = ~clk;

  xfer_splitter #(.ADDR_W(AW), .LANE_W(8)) u0 (
    .clk(clk), .rst(rst), .req_start(req_start), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .rd_data(rd_data)
  );

  // slave: byte memory, same-clock read, write on the edge
  logic [7:0] mem [MEM];
  logic [7:0] refm [MEM];
  logic [5:0] sa;
  assign sa = bus_addr[5:0];
  assign bus_rdata = {mem[sa], mem[sa + 6'd1]};

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEM; i++) mem[i] <= 8'(i * 37 + 5);
    end else if (bus_valid && bus_we) begin
      if (bus_be[1]) mem[sa]        <= bus_wdata[15:8];
      if (bus_be[0]) mem[sa + 6'd1] <= bus_wdata[7:0];
    end
  end

  int errs = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string count_tag(input int sz, input int off);
    if (sz == 3)                       return "R10";
    if (sz == 0 || (sz == 1 && off == 0)) return "R2";
    if (sz == 2 && off == 1)           return "R4";
    return "R3";
  endfunction

  task automatic run_op(input bit wr, input int sz, input int addr,
                        input logic [31:0] wd, input bit glitch);
    int n, off, ncyc, base, j;
    logic [31:0] prev_rd, exp_rd;
    n    = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    off  = addr % 2;
    ncyc = (off + n + 1) / 2;
    base = addr - off;
    prev_rd = rd_data;

    @(negedge clk);
    req_write = wr; req_size = 2'(sz); req_addr = AW'(addr); req_wdata = wd; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(bus_valid === 1'b1, "R11", "first cycle launch", 32'(bus_valid), 32'd1);

    j = 0;
    for (int t = 0; t < 8 && !done; t++) begin
      if (bus_valid) begin
        int rh, rl;
        bit eh, el;
        rh = 2 * j - off;
        rl = 2 * j + 1 - off;
        eh = (rh >= 0) && (rh < n);
        el = (rl >= 0) && (rl < n);
        chk(bus_addr == AW'(base + 2 * j), "R5", "cycle address", 32'(bus_addr), 32'(base + 2 * j));
        chk(bus_be == {eh, el}, "R6", "lane enables", 32'(bus_be), 32'({eh, el}));
        chk(bus_we == wr, "R7", "write flag", 32'(bus_we), 32'(wr));
        if (wr && eh) chk(bus_wdata[15:8] == wd[8*(n-1-rh) +: 8], "R7", "high lane data",
                          32'(bus_wdata[15:8]), 32'(wd[8*(n-1-rh) +: 8]));
        if (wr && el) chk(bus_wdata[7:0] == wd[8*(n-1-rl) +: 8], "R7", "low lane data",
                          32'(bus_wdata[7:0]), 32'(wd[8*(n-1-rl) +: 8]));
        j++;
        if (glitch && j == 1) begin
          req_start = 1'b1; req_addr = '0; req_size = 2'd0; req_write = ~wr;
        end
        if (glitch && j == 2) req_start = 1'b0;
      end
      @(negedge clk);
    end
    req_start = 1'b0;
    chk(done === 1'b1, "R8", "done after last cycle", 32'(done), 32'd1);
    chk(j == ncyc, glitch ? "R9" : count_tag(sz, off), "bus cycle count", 32'(j), 32'(ncyc));

    if (wr) begin
      for (int k = 0; k < n; k++) refm[addr + k] = wd[8*(n-1-k) +: 8];
      chk(rd_data == prev_rd, "R8", "rd_data held on write", rd_data, prev_rd);
    end else begin
      exp_rd = '0;
      for (int k = 0; k < n; k++) exp_rd = {exp_rd[23:0], refm[addr + k]};
      chk(rd_data == exp_rd, "R8", "read merge", rd_data, exp_rd);
    end

    @(negedge clk);
    chk(done === 1'b0 && bus_valid === 1'b0, glitch ? "R9" : "R8",
        "single done, no stray cycle", {30'd0, done, bus_valid}, 32'd0);
    if (wr) begin
      for (int k = 0; k < MEM; k++)
        if (mem[k] != refm[k]) chk(1'b0, "R7", "memory byte", 32'(mem[k]), 32'(refm[k]));
      chk(1'b1, "R7", "memory image", 32'd0, 32'd0);
    end
  endtask

  initial begin
    #(200000 * 4);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM; i++) refm[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    chk(bus_valid === 1'b0 && done === 1'b0 && bus_be === 2'b00, "R1", "outputs in reset",
        {29'd0, bus_valid, done, |bus_be}, 32'd0);
    chk(rd_data === 32'd0, "R1", "rd_data in reset", rd_data, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_valid === 1'b0 && done === 1'b0, "R1", "idle after reset",
        {30'd0, bus_valid, done}, 32'd0);

    for (int sz = 0; sz < 4; sz++) begin
      for (int off = 0; off < 8; off++) begin
        logic [31:0] wd;
        wd = 32'h1F2E3D4C ^ (32'(sz * 8 + off) * 32'h01030507);
        run_op(1'b1, sz, 16 + off, wd, 1'b0);
        run_op(1'b0, sz, 16 + off, 32'd0, 1'b0);
      end
    end

    // start strobes raised mid-transfer must be ignored (R9)
    run_op(1'b0, 2, 33, 32'd0, 1'b1);
    run_op(1'b1, 2, 41, 32'hC0FFEE17, 1'b1);
    run_op(1'b0, 2, 41, 32'd0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule